// File: doc/BRIEF.md
# Data-Driven Gated Multibit Register Bank

This block is a wide pipeline register split into groups of `GROUP` bits. Each group acts as one multibit flip-flop with one shared enable. The enable is derived from the data itself. On every cycle the group compares its incoming bits with the bits it holds. When nothing in the group would change, the load is suppressed for that cycle. When any one bit differs, the whole group is clocked. The comparison result for each group is also driven out, so a power model can count clocked group-cycles against gated ones.

Two implementations of the gate can be chosen with a parameter. The first is a plain clock enable on the group's flops. The second is a modelled clock-gating cell: a latch that is open while the clock is low, feeding an AND gate on the clock. Both implementations give the same register contents cycle for cycle. When `WIDTH` is not a multiple of `GROUP`, the last group is narrower and has its own enable.

Top module: `gated_mbff_bank`

## Requirements
- R1: After every rising edge at which `rst_n` was high, `q_out` equals the `d_in` value present at that edge, so the latency is one cycle.
- R2: Group g covers bits `[g*GROUP +: GROUP]`. The last group covers whatever bits remain. `grp_active[g]` is bit g of that output.
- R3: `grp_active[g]` is high in the same cycle, with no register in between, exactly when at least one `d_in` bit of group g differs from the matching `q_out` bit.
- R4: A group whose `grp_active` bit is low keeps its stored bits across the edge.
- R5: A difference in any single bit of a group loads all bits of that group, including the bits that did not change.
- R6: While `rst_n` is low at a rising edge, every group loads zero. This holds even when the group's input already equals its stored value.
- R7: With `GATE_STYLE` = 1 (latch-based gated clock), the register contents and `grp_active` match the `GATE_STYLE` = 0 (clock enable) build on every cycle.
- R8: A `GROUP` of 2 and a `GROUP` of 4 are both supported. A `WIDTH` that is not a multiple of `GROUP` gives a short final group that is gated on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| d_in | input | WIDTH | Next data word |
| q_out | output | WIDTH | Stored data word |
| grp_active | output | ceil(WIDTH/GROUP) | Per-group load flag for the current cycle |

## Verification
The `grp_active` flags are combinational. The bench therefore checks them one time unit after it drives `d_in` on the falling edge, before the next rising edge. `q_out` changes one rising edge after the stimulus. It is sampled one time unit after that edge and compared with an ungated reference value that the bench keeps. The sweep steps through all 4096 ordered pairs of 6-bit words for three builds: groups of four with a 2-bit remainder, groups of two, and the latch-gated variant. Every transition is therefore seen from every stored value. Resets are applied both with differing data and with equal data.

// File: rtl/gmb_pkg.sv
// Package: shared group geometry helpers for the gated multibit bank.
// Assumes group size >= 1 and width >= 1.
package gmb_pkg;

    // Number of groups needed to cover a word of w bits in groups of k.
    function automatic int grp_count(input int w, input int k);
        return (w + k - 1) / k;
    endfunction

    // Lowest bit index of group g.
    function automatic int grp_lo(input int g, input int k);
        return g * k;
    endfunction

    // Bit width of group g; the last group may be short.
    function automatic int grp_width(input int g, input int w, input int k);
        int rest;
        rest = w - g * k;
        return (rest < k) ? rest : k;
    endfunction

endpackage

// File: rtl/gmb_change_detect.sv
// Module: gmb_change_detect
// Compares one group's next data with its stored data and raises a
// single flag when any bit would change. Purely combinational.
module gmb_change_detect #(
    parameter int GW = 4
) (
    input  logic [GW-1:0] nxt,
    input  logic [GW-1:0] cur,
    output logic          differs
);

    // Flag any bit mismatch within the group.
    always_comb begin
        differs = |(nxt ^ cur);
    end

endmodule

// File: rtl/gmb_group_reg.sv
// Module: gmb_group_reg
// One multibit register group with a single shared load control.
// GATE_STYLE 0: plain clock enable on the flops.
// GATE_STYLE 1: modelled gating cell, a latch open while clk is low,
//               ANDed with clk so the gated clock cannot glitch high.
// Assumes the synchronous reset is folded into the enable by the caller.
module gmb_group_reg #(
    parameter int GW         = 4,
    parameter int GATE_STYLE = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [GW-1:0] d,
    output logic [GW-1:0] q
);

    logic [GW-1:0] nxt_val;

    // Select zero during reset, otherwise the incoming data.
    always_comb begin
        nxt_val = rst_n ? d : '0;
    end

    generate
        if (GATE_STYLE == 1) begin : g_latch_gate
            logic en_lat;
            logic gclk;

            // Capture the enable while the clock is low.
            always_latch begin
                if (!clk) en_lat = load;
            end

            // Form the gated clock from the held enable.
            always_comb begin
                gclk = clk & en_lat;
            end

            // Store the group on the gated clock.
            always_ff @(posedge gclk) begin
                q <= nxt_val;
            end
        end else begin : g_clk_enable
            // Store the group when the shared enable is high.
            always_ff @(posedge clk) begin
                if (load) q <= nxt_val;
            end
        end
    endgenerate

endmodule

// File: rtl/gated_mbff_bank.sv
// Module: gated_mbff_bank
// Wide register split into GROUP-bit multibit groups. Each group loads
// only when its data differs from its contents, or during reset.
// Assumes GROUP >= 1 and WIDTH >= 1; the final group may be short.
module gated_mbff_bank
    import gmb_pkg::*;
#(
    parameter int WIDTH      = 24,
    parameter int GROUP      = 4,
    parameter int GATE_STYLE = 0,
    localparam int NGRP      = grp_count(WIDTH, GROUP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out,
    output logic [NGRP-1:0]  grp_active
);

    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_grp
            localparam int LO = grp_lo(g, GROUP);
            localparam int GW = grp_width(g, WIDTH, GROUP);

            logic          diff;
            logic          load;
            logic [GW-1:0] q_g;

            gmb_change_detect #(.GW(GW)) u_cmp (
                .nxt     (d_in[LO +: GW]),
                .cur     (q_g),
                .differs (diff)
            );

            // Reset overrides the data-driven enable.
            always_comb begin
                load = diff | ~rst_n;
            end

            gmb_group_reg #(.GW(GW), .GATE_STYLE(GATE_STYLE)) u_reg (
                .clk   (clk),
                .rst_n (rst_n),
                .load  (load),
                .d     (d_in[LO +: GW]),
                .q     (q_g)
            );

            // Drive the group's slice of the outputs.
            always_comb begin
                q_out[LO +: GW] = q_g;
                grp_active[g]   = diff;
            end
        end
    endgenerate

endmodule

// File: rtl/gated_mbff_bank_sva.sv
// Module: gated_mbff_bank_sva
// Checker for gated_mbff_bank, attached by bind below.
module gated_mbff_bank_sva
    import gmb_pkg::*;
#(
    parameter int WIDTH = 24,
    parameter int GROUP = 4,
    localparam int NGRP = grp_count(WIDTH, GROUP)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] d_in,
    input logic [WIDTH-1:0] q_out,
    input logic [NGRP-1:0]  grp_active
);

    // R1: one-cycle transfer when out of reset
    p_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> q_out == $past(d_in));

    // R6: reset loads zero
    p_reset_zero_r6: assert property (@(posedge clk)
        !rst_n |=> q_out == '0);

    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_chk
            localparam int LO = grp_lo(g, GROUP);
            localparam int GW = grp_width(g, WIDTH, GROUP);

            // R4: an idle group keeps its bits
            p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
                !grp_active[g] |=> $stable(q_out[LO +: GW]));

            // R3: an idle group already held the incoming data
            p_idle_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
                !grp_active[g] |=> q_out[LO +: GW] == $past(d_in[LO +: GW]));

            // R5: an active group changes its contents
            p_active_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
                grp_active[g] |=> q_out[LO +: GW] != $past(q_out[LO +: GW]));
        end
    endgenerate

endmodule

bind gated_mbff_bank gated_mbff_bank_sva #(.WIDTH(WIDTH), .GROUP(GROUP)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .d_in       (d_in),
    .q_out      (q_out),
    .grp_active (grp_active)
);

// File: tb/test_gated_mbff_bank.sv
module test_gated_mbff_bank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] d = '0;
    logic [5:0] ref_q = '0;
    logic [5:0] q4, q2, ql;
    logic [1:0] a4, al;
    logic [2:0] a2;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gated_mbff_bank #(.WIDTH(6), .GROUP(4), .GATE_STYLE(0)) i_gated_mbff_bank (
        .clk(clk), .rst_n(rst_n), .d_in(d), .q_out(q4), .grp_active(a4));
    gated_mbff_bank #(.WIDTH(6), .GROUP(2), .GATE_STYLE(0)) i_gated_mbff_bank_k2 (
        .clk(clk), .rst_n(rst_n), .d_in(d), .q_out(q2), .grp_active(a2));
    gated_mbff_bank #(.WIDTH(6), .GROUP(4), .GATE_STYLE(1)) i_gated_mbff_bank_lg (
        .clk(clk), .rst_n(rst_n), .d_in(d), .q_out(ql), .grp_active(al));

    // Expected group flags: group of bit i is i/k.
    function automatic logic [2:0] exp_act(input logic [5:0] x, input logic [5:0] y, input int k);
        logic [2:0] r;
        r = '0;
        for (int i = 0; i < 6; i++) if (x[i] != y[i]) r[i / k] = 1'b1;
        return r;
    endfunction

    task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", req, act, exp);
        end
    endtask

    // Apply one word: check flags before the edge, outputs after it.
    task automatic step(input logic [5:0] v, input logic rst_v);
        @(negedge clk);
        d = v;
        rst_n = rst_v;
        #1;
        chk("R3 R2 k4 flags", {4'b0, a4}, {3'b0, exp_act(v, ref_q, 4)});
        chk("R8 R3 k2 flags", {3'b0, a2}, {3'b0, exp_act(v, ref_q, 2)});
        chk("R7 latch flags", {4'b0, al}, {3'b0, exp_act(v, ref_q, 4)});
        @(posedge clk);
        ref_q = rst_v ? v : 6'd0;
        #1;
        chk(rst_v ? "R1 R4 R5 k4 data" : "R6 k4 reset", q4, ref_q);
        chk(rst_v ? "R8 k2 data" : "R6 k2 reset", q2, ref_q);
        chk(rst_v ? "R7 latch data" : "R6 latch reset", ql, ref_q);
    endtask

    initial begin
        step(6'h00, 1'b0);
        step(6'h00, 1'b0);
        // Exhaustive ordered pairs: every word after every stored word.
        for (int a = 0; a < 64; a++) begin
            for (int b = 0; b < 64; b++) begin
                step(6'(a), 1'b1);
                step(6'(b), 1'b1);
            end
        end
        // R6: reset with differing data, then with equal data.
        step(6'h2D, 1'b1);
        step(6'h3F, 1'b0);
        step(6'h15, 1'b1);
        step(6'h15, 1'b0);
        step(6'h00, 1'b0);
        step(6'h21, 1'b1);
        done = 1;
    end

    initial begin
        for (int n = 0; n < 150000 && !done; n++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule